// File: doc/BRIEF.md
# Strided Burst Memory Port

This block is a single access port in front of an internal synchronous RAM. Callers hand it a read base address or a write base address on separate valid/ready channels. Before the address, they may also hand it a stride and a transfer count. The port then runs a burst of transfers, moving the address forward by the stride after each one. Every transfer produces one word on a single result channel, and a one-bit tag on that channel tells the receiver what kind of word it is.

A read burst returns the stored words. A write burst consumes one data word per transfer. Once each word has been written, the port returns the address the next write of the burst would use, so a producer can chain writes without tracking addresses itself.

The port handles one operation at a time. It never overlaps a read with a write, and it takes no new base address until the current burst has issued its last transfer. The RAM read takes one cycle. A one-entry result register absorbs that cycle, so the result holds steady under backpressure.

Top module: `spb_port`

## Requirements
- R1: A read burst returns `n` words with tag 0. They are the contents of base, base+S, base+2S and so on, where S is the stride and `n` is the count; addresses wrap modulo 2^ADDR_W.
- R2: Each write transfer stores its data word at the current address, then returns one result with tag 1. The result data is the current address plus the stride, zero-extended to the data width, and it appears only after the store has taken effect.
- R3: With no stride or count pending when a burst starts, the burst uses stride 0 and count 1. A pending count of 0 also gives a single transfer.
- R4: A stride or count handed in before an address applies only to the next burst that starts. It is consumed at that start, so a following burst with no new setup falls back to the defaults of R3.
- R5: No base address is accepted while the current burst still has transfers to issue. A read base and a write base are never accepted in the same cycle. When both could start, the write starts first.
- R6: A write transfer is accepted only when write data is valid and the result channel has space in the same cycle. The first transfer of a write burst also needs its write address valid in that cycle. If any of these is missing, nothing is accepted and nothing is produced.
- R7: A read at an address at or above DEPTH returns 0. A write at such an address changes no stored word but still returns its tag-1 result.
- R8: While the result is valid and not taken, its data and tag stay unchanged.
- R9: After a synchronous active-low reset, no result is valid, no burst is in progress, and no stride or count is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_addr_valid | input | 1 | Read base address offered |
| rd_addr | input | ADDR_W | Read base address |
| rd_addr_ready | output | 1 | Read base address taken |
| wr_addr_valid | input | 1 | Write base address offered |
| wr_addr | input | ADDR_W | Write base address |
| wr_addr_ready | output | 1 | Write base address taken |
| wr_data_valid | input | 1 | Write data offered |
| wr_data | input | DATA_W | Write data word |
| wr_data_ready | output | 1 | Write data taken |
| stride_valid | input | 1 | Stride setup offered |
| stride | input | ADDR_W | Address step for the next burst |
| stride_ready | output | 1 | Stride setup taken |
| count_valid | input | 1 | Count setup offered |
| count | input | CNT_W | Transfer count for the next burst |
| count_ready | output | 1 | Count setup taken |
| out_valid | output | 1 | Result word valid |
| out_ready | input | 1 | Receiver takes the result |
| out_data | output | DATA_W | Read word or next write address |
| out_flag | output | 1 | 0 for a read word, 1 for a write result |

## Verification
On every cycle, the assertions check that the held result stays stable, that base addresses are taken only while the port is idle and never two at once, that a write is taken only with its address, data and result space all present, and that a write result follows each accepted write. Only the directed scenarios can show the values themselves: strided read and write sequences, the fallback to default stride and count, the consuming of setup, zero returned for out-of-range reads, and the order of results when a write and a read compete.

// File: rtl/spb_pkg.sv
// Package: shared types for the strided burst port.
// Assumes: nothing beyond IEEE 1800-2017.
package spb_pkg;

    // Kind of burst currently running
    typedef enum logic {
        SPB_RD = 1'b0,
        SPB_WR = 1'b1
    } spb_op_e;

endpackage

// File: rtl/spb_ram.sv
// Module: spb_ram
// Synchronous single-port storage with a registered read.
// Assumes: DEPTH <= 2**ADDR_W, and read and write are never requested together.
// Addresses at or above DEPTH read as zero, and writes to them are dropped.
module spb_ram #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;
    logic              inr_q;
    logic              in_range;
    logic [IDX_W-1:0]  idx;

    // Range decode: a full-size array needs no compare
    generate
        if (DEPTH >= (2 ** ADDR_W)) begin : g_full
            assign in_range = 1'b1;
        end else begin : g_part
            localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);
            assign in_range = (addr < LIMIT);
        end
    endgenerate

    assign idx = addr[IDX_W-1:0];

    // Storage write and registered read
    always_ff @(posedge clk) begin
        if (we && in_range) begin
            mem[idx] <= wdata;
        end
        if (re) begin
            rd_q  <= mem[idx];
            inr_q <= in_range;
        end
    end

    assign rdata = inr_q ? rd_q : '0;

endmodule

// File: rtl/spb_seq.sv
// Module: spb_seq
// Burst sequencer: holds pending stride/count setup, starts bursts, steps the address.
// Assumes: issue_ok says the result path can take one transfer this cycle.
// A write start has priority over a read start.
module spb_seq
    import spb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_addr_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_addr_ready,
    input  logic              wr_addr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wr_addr_ready,
    input  logic              wr_data_valid,
    output logic              wr_data_ready,
    input  logic              stride_valid,
    input  logic [ADDR_W-1:0] stride,
    output logic              stride_ready,
    input  logic              count_valid,
    input  logic [CNT_W-1:0]  count,
    output logic              count_ready,
    input  logic              issue_ok,
    output logic              ram_we,
    output logic              ram_re,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [ADDR_W-1:0] ack_addr,
    output logic              busy
);
    logic [CNT_W-1:0]  remain_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stride_q;
    spb_op_e           op_q;
    logic              s_pend_q;
    logic [ADDR_W-1:0] s_val_q;
    logic              c_pend_q;
    logic [CNT_W-1:0]  c_val_q;

    logic              idle;
    logic              wr_start;
    logic              rd_start;
    logic              wr_cont;
    logic              rd_cont;
    logic              start;
    logic              step;
    logic [ADDR_W-1:0] s_eff;
    logic [CNT_W-1:0]  c_eff;
    logic [ADDR_W-1:0] step_by;
    logic              s_take;
    logic              c_take;

    // Effective setup for a burst starting this cycle
    always_comb begin
        s_eff = s_pend_q ? s_val_q : '0;
        c_eff = (c_pend_q && (c_val_q != '0)) ? c_val_q : CNT_W'(1);
    end

    // Start/continue decisions and handshake outputs
    always_comb begin
        idle     = (remain_q == '0);
        wr_start = idle && wr_addr_valid && wr_data_valid && issue_ok;
        rd_start = idle && !wr_start && rd_addr_valid && issue_ok;
        wr_cont  = !idle && (op_q == SPB_WR) && wr_data_valid && issue_ok;
        rd_cont  = !idle && (op_q == SPB_RD) && issue_ok;
        start    = wr_start || rd_start;
        step     = wr_cont || rd_cont;

        rd_addr_ready = rd_start;
        wr_addr_ready = wr_start;
        wr_data_ready = wr_start || wr_cont;
        stride_ready  = !s_pend_q;
        count_ready   = !c_pend_q;
        s_take        = stride_valid && !s_pend_q;
        c_take        = count_valid && !c_pend_q;

        ram_we   = wr_start || wr_cont;
        ram_re   = rd_start || rd_cont;
        if (!idle) begin
            ram_addr = addr_q;
        end else if (wr_start) begin
            ram_addr = wr_addr;
        end else begin
            ram_addr = rd_addr;
        end
        step_by  = idle ? s_eff : stride_q;
        ack_addr = ram_addr + step_by;
        busy     = !idle;
    end

    // Burst state: remaining count, current address, stride and kind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            addr_q   <= '0;
            stride_q <= '0;
            op_q     <= SPB_RD;
        end else if (start) begin
            remain_q <= c_eff - CNT_W'(1);
            addr_q   <= ack_addr;
            stride_q <= s_eff;
            op_q     <= wr_start ? SPB_WR : SPB_RD;
        end else if (step) begin
            remain_q <= remain_q - CNT_W'(1);
            addr_q   <= ack_addr;
        end
    end

    // Pending setup: captured when offered, consumed by the next start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_pend_q <= 1'b0;
            c_pend_q <= 1'b0;
            s_val_q  <= '0;
            c_val_q  <= '0;
        end else begin
            if (s_take) begin
                s_pend_q <= 1'b1;
                s_val_q  <= stride;
            end else if (start) begin
                s_pend_q <= 1'b0;
            end
            if (c_take) begin
                c_pend_q <= 1'b1;
                c_val_q  <= count;
            end else if (start) begin
                c_pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spb_outreg.sv
// Module: spb_outreg
// One-entry result register that also tracks the RAM read in flight.
// Assumes: a read issue and a write result never land in the same cycle (issue_ok gates both).
module spb_outreg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic              ack_load,
    input  logic [DATA_W-1:0] ack_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_flag,
    output logic              issue_ok
);
    logic              pend_q;
    logic              val_q;
    logic [DATA_W-1:0] data_q;
    logic              flag_q;

    // Space for one more transfer: nothing in flight, register empty or draining
    assign issue_ok = !pend_q && (!val_q || out_ready);

    // Read-in-flight marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= rd_issue;
        end
    end

    // Result register fill and drain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q  <= 1'b0;
            data_q <= '0;
            flag_q <= 1'b0;
        end else if (pend_q) begin
            val_q  <= 1'b1;
            data_q <= ram_rdata;
            flag_q <= 1'b0;
        end else if (ack_load) begin
            val_q  <= 1'b1;
            data_q <= ack_data;
            flag_q <= 1'b1;
        end else if (out_ready) begin
            val_q  <= 1'b0;
        end
    end

    assign out_valid = val_q;
    assign out_data  = data_q;
    assign out_flag  = flag_q;

endmodule

// File: rtl/spb_port.sv
// Module: spb_port (top)
// Strided burst memory port: sequencer, RAM and result register.
// Assumes: DATA_W >= ADDR_W, and DEPTH <= 2**ADDR_W.
module spb_port #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 8,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_addr_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_addr_ready,
    input  logic              wr_addr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wr_addr_ready,
    input  logic              wr_data_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_data_ready,
    input  logic              stride_valid,
    input  logic [ADDR_W-1:0] stride,
    output logic              stride_ready,
    input  logic              count_valid,
    input  logic [CNT_W-1:0]  count,
    output logic              count_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_flag
);
    logic              issue_ok;
    logic              ram_we;
    logic              ram_re;
    logic [ADDR_W-1:0] ram_addr;
    logic [ADDR_W-1:0] ack_addr;
    logic [DATA_W-1:0] ram_rdata;
    logic [DATA_W-1:0] ack_data;
    logic              busy;

    assign ack_data = DATA_W'(ack_addr);

    spb_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_valid(rd_addr_valid), .rd_addr(rd_addr), .rd_addr_ready(rd_addr_ready),
        .wr_addr_valid(wr_addr_valid), .wr_addr(wr_addr), .wr_addr_ready(wr_addr_ready),
        .wr_data_valid(wr_data_valid), .wr_data_ready(wr_data_ready),
        .stride_valid(stride_valid), .stride(stride), .stride_ready(stride_ready),
        .count_valid(count_valid), .count(count), .count_ready(count_ready),
        .issue_ok(issue_ok), .ram_we(ram_we), .ram_re(ram_re),
        .ram_addr(ram_addr), .ack_addr(ack_addr), .busy(busy)
    );

    spb_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) ram_i (
        .clk(clk), .we(ram_we), .re(ram_re), .addr(ram_addr),
        .wdata(wr_data), .rdata(ram_rdata)
    );

    spb_outreg #(.DATA_W(DATA_W)) out_i (
        .clk(clk), .rst_n(rst_n), .rd_issue(ram_re), .ram_rdata(ram_rdata),
        .ack_load(ram_we), .ack_data(ack_data), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_flag(out_flag),
        .issue_ok(issue_ok)
    );

endmodule

// File: rtl/spb_port_chk.sv
// Module: spb_port_chk
// Cycle-by-cycle property checker for spb_port, attached through bind.
// Assumes: sees the top's ports plus its internal busy signal.
module spb_port_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_addr_valid,
    input logic              rd_addr_ready,
    input logic              wr_addr_valid,
    input logic              wr_addr_ready,
    input logic              wr_data_valid,
    input logic              wr_data_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_flag,
    input logic              busy
);
    // R8: a held result does not change
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_flag)));

    // R5: never two base addresses in one cycle
    a_r5_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_addr_ready && wr_addr_ready));

    // R5: base addresses only while idle
    a_r5_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_ready || wr_addr_ready) |-> !busy);

    // R6: write start only with address, data and result space together
    a_r6_joint_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_addr_ready |-> (wr_addr_valid && wr_data_valid && wr_data_ready
                           && (!out_valid || out_ready)));

    // R1: read address taken only when offered
    a_r1_ready_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr_ready |-> rd_addr_valid);

    // R2: every accepted write data word is followed by a tag-1 result
    a_r2_write_result: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_ready |=> (out_valid && out_flag));

    // R9: reset empties the result register and stops any burst
    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !busy));

endmodule

bind spb_port spb_port_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_valid(rd_addr_valid), .rd_addr_ready(rd_addr_ready),
    .wr_addr_valid(wr_addr_valid), .wr_addr_ready(wr_addr_ready),
    .wr_data_valid(wr_data_valid), .wr_data_ready(wr_data_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_flag(out_flag), .busy(busy)
);

// File: tb/spb_port_tb.sv
// Bench: directed scenarios for spb_port, one task each, self-checking.
module spb_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_addr_valid = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic        rd_addr_ready;
    logic        wr_addr_valid = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic        wr_addr_ready;
    logic        wr_data_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_data_ready;
    logic        stride_valid = 1'b0;
    logic [7:0]  stride = '0;
    logic        stride_ready;
    logic        count_valid = 1'b0;
    logic [7:0]  count = '0;
    logic        count_ready;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_data;
    logic        out_flag;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;
    logic [16:0] rq[$];

    always #5 clk = ~clk;

    spb_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_valid(rd_addr_valid), .rd_addr(rd_addr), .rd_addr_ready(rd_addr_ready),
        .wr_addr_valid(wr_addr_valid), .wr_addr(wr_addr), .wr_addr_ready(wr_addr_ready),
        .wr_data_valid(wr_data_valid), .wr_data(wr_data), .wr_data_ready(wr_data_ready),
        .stride_valid(stride_valid), .stride(stride), .stride_ready(stride_ready),
        .count_valid(count_valid), .count(count), .count_ready(count_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_flag(out_flag)
    );

    // Result monitor: records each handshake mid-cycle
    always @(negedge clk) begin
        #2;
        if (rst_n && out_valid && out_ready) rq.push_back({out_flag, out_data});
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic wait_q(input int n);
        int t = 0;
        while (rq.size() < n && t < 60) begin
            @(negedge clk); #3; t++;
        end
    endtask

    task automatic idle_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #3;
    endtask

    task automatic send_setup(input logic [7:0] s, input logic [7:0] c);
        @(negedge clk);
        stride = s; count = c; stride_valid = 1'b1; count_valid = 1'b1;
        #1;
        while (!(stride_ready && count_ready)) begin @(negedge clk); #1; end
        @(negedge clk);
        stride_valid = 1'b0; count_valid = 1'b0;
    endtask

    task automatic send_read(input logic [7:0] a);
        @(negedge clk);
        rd_addr = a; rd_addr_valid = 1'b1;
        #1;
        while (!rd_addr_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        rd_addr_valid = 1'b0;
    endtask

    task automatic send_write(input logic [7:0] a, input int n, input logic [15:0] d0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_addr_valid = (i == 0);
            wr_addr = a;
            wr_data = d0 + 16'(i);
            wr_data_valid = 1'b1;
            #1;
            while (!wr_data_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        wr_addr_valid = 1'b0; wr_data_valid = 1'b0;
    endtask

    // R9: reset state
    task automatic t_reset();
        idle_wait(3);
        chk("R9 out_valid in reset", out_valid, 0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R9 out_valid after reset", out_valid, 0);
        chk("R9 stride_ready", stride_ready, 1);
        chk("R9 count_ready", count_ready, 1);
        chk("R9 rd_addr_ready idle", rd_addr_ready, 0);
    endtask

    // R2, R3: single write and read with default setup
    task automatic t_single();
        rq.delete();
        send_write(8'd5, 1, 16'h1234);
        wait_q(1);
        chk("R2 R3 single write result", rq[0], {1'b1, 16'h0005});
        send_read(8'd5);
        wait_q(2);
        chk("R3 single read data", rq[1], {1'b0, 16'h1234});
    endtask

    // R1, R2, R4: strided bursts and consumed setup
    task automatic t_bursts();
        rq.delete();
        send_setup(8'd3, 8'd4);
        send_write(8'd10, 4, 16'hA000);
        wait_q(4);
        for (int i = 0; i < 4; i++)
            chk("R2 burst write next address", rq[i], {1'b1, 16'(13 + 3 * i)});
        rq.delete();
        send_setup(8'd3, 8'd4);
        send_read(8'd10);
        wait_q(4);
        for (int i = 0; i < 4; i++)
            chk("R1 strided read word", rq[i], {1'b0, 16'hA000 + 16'(i)});
        rq.delete();
        send_read(8'd13);
        idle_wait(8);
        chk("R4 setup consumed: one word", rq.size(), 1);
        chk("R4 default read data", rq[0], {1'b0, 16'hA001});
    endtask

    // R3: count of zero means one transfer
    task automatic t_count_zero();
        rq.delete();
        send_setup(8'd5, 8'd0);
        send_read(8'd16);
        idle_wait(8);
        chk("R3 count zero gives one word", rq.size(), 1);
        chk("R3 count zero data", rq[0], {1'b0, 16'hA002});
    endtask

    // R7: out-of-range write dropped, read returns zero
    task automatic t_oob();
        rq.delete();
        send_write(8'd200, 1, 16'h5555);
        wait_q(1);
        chk("R7 out-of-range write result", rq[0], {1'b1, 16'd200});
        send_read(8'd200);
        wait_q(2);
        chk("R7 out-of-range read is zero", rq[1], {1'b0, 16'h0000});
    endtask

    // R8, R5: backpressure holds output and blocks new base address
    task automatic t_backpressure();
        rq.delete();
        send_setup(8'd1, 8'd3);
        send_write(8'd30, 3, 16'hD000);
        wait_q(3);
        rq.delete();
        @(negedge clk); out_ready = 1'b0;
        send_setup(8'd1, 8'd3);
        send_read(8'd30);
        @(negedge clk);
        rd_addr = 8'd10; rd_addr_valid = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk("R5 no base address while busy", rd_addr_ready, 0);
            chk("R8 held valid", out_valid, 1);
            chk("R8 held data", {out_flag, out_data}, {1'b0, 16'hD000});
        end
        @(negedge clk); out_ready = 1'b1; #1;
        while (!rd_addr_ready) begin @(negedge clk); #1; end
        @(negedge clk); rd_addr_valid = 1'b0;
        wait_q(4);
        chk("R1 backpressured word 0", rq[0], {1'b0, 16'hD000});
        chk("R1 backpressured word 1", rq[1], {1'b0, 16'hD001});
        chk("R1 backpressured word 2", rq[2], {1'b0, 16'hD002});
        chk("R5 next burst after finish", rq[3], {1'b0, 16'hA000});
    endtask

    // R6: write needs address, data and result space together
    task automatic t_write_joint();
        rq.delete();
        @(negedge clk); out_ready = 1'b0;
        send_read(8'd5);
        @(negedge clk);
        wr_addr = 8'd40; wr_addr_valid = 1'b1; wr_data = 16'h4040;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk("R6 no write without data", wr_addr_ready, 0);
        end
        @(negedge clk); wr_data_valid = 1'b1;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); #1;
            chk("R6 no write without result space", wr_addr_ready, 0);
        end
        @(negedge clk); out_ready = 1'b1; #1;
        chk("R6 write taken once space frees", wr_addr_ready, 1);
        @(negedge clk); wr_addr_valid = 1'b0; wr_data_valid = 1'b0;
        wait_q(2);
        chk("R6 held read delivered first", rq[0], {1'b0, 16'h1234});
        chk("R6 write result", rq[1], {1'b1, 16'd40});
        send_read(8'd40);
        wait_q(3);
        chk("R6 write stored", rq[2], {1'b0, 16'h4040});
    endtask

    // R5: write wins when both start together
    task automatic t_priority();
        rq.delete();
        @(negedge clk);
        rd_addr = 8'd5; rd_addr_valid = 1'b1;
        wr_addr = 8'd41; wr_addr_valid = 1'b1; wr_data = 16'hBEEF; wr_data_valid = 1'b1;
        #1;
        chk("R5 write start chosen", wr_addr_ready, 1);
        chk("R5 read held back", rd_addr_ready, 0);
        @(negedge clk); wr_addr_valid = 1'b0; wr_data_valid = 1'b0; #1;
        while (!rd_addr_ready) begin @(negedge clk); #1; end
        @(negedge clk); rd_addr_valid = 1'b0;
        wait_q(2);
        chk("R5 write result first", rq[0], {1'b1, 16'd41});
        chk("R5 read result second", rq[1], {1'b0, 16'h1234});
    endtask

    initial begin
        t_reset();
        t_single();
        t_bursts();
        t_count_zero();
        t_oob();
        t_backpressure();
        t_write_joint();
        t_priority();
        idle_wait(2);
        finish_up();
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule